// File: doc/BRIEF.md
# Timeplate Vector Expander

The expander turns a stream of pattern vectors into a stream of per-sample pin controls. It runs at a fixed sample rate and repeats each vector over a programmable number of samples, which lets a fixed-rate pin card behave as if it had a timing set. Each vector carries a 3-bit state code for every channel. A code either drives the pin (low, high, released, or unchanged from the previous vector) or tells the comparator what to expect (low, high, or don't-care).

A small timeplate holds four values: the vector length in samples, the sample at which a new drive value reaches the pin, and the first and last samples of the compare strobe. At reset the timeplate is 20 samples per vector, with the drive edge at sample 1 and the strobe at samples 11 and 12. Samples are counted from 0, where sample 0 is the first cycle after the vector was accepted. A timeplate write is checked before it is applied. An accepted write aborts the current vector, and the pins keep whatever they were driving.

Vectors arrive on a valid/ready handshake. A vector is taken only when the block is idle or is issuing the last sample of the current vector. If no vector is ready at that point, the block goes idle, holds the pins and raises a starvation flag.

Top module: `tpx_expander`

## Requirements
- R1: After reset, drv_data and drv_en are all 0, cmp_valid and exp_val are all 0, vec_ready is 1, and underrun, cfg_ack and cfg_nack are 0.
- R2: A vector is accepted on a clock edge where vec_valid and vec_ready are both 1. vec_ready is 1 only when the block is idle or at the last sample of a vector, and it is 0 in any cycle where cfg_wr is 1.
- R3: While vectors are supplied back to back, each vector occupies exactly spv samples. vec_ready is 1 only in sample spv-1 of each vector.
- R4: Code 0 (drive low) and code 1 (drive high) set drv_data to 0 or 1 and drv_en to 1, starting at sample edge_at of the vector. That value holds until the edge of a later vector changes it.
- R5: Code 2 (release), and codes 4, 5, 6 and 7 (compare codes), clear drv_en from sample edge_at. drv_data keeps its previous value.
- R6: Code 3 (repeat) leaves drv_data and drv_en exactly as the previous vector left them.
- R7: cmp_valid for a channel is 1 only in samples win_lo through win_hi inclusive, and only when the channel's code is 4 (expect low) or 5 (expect high). exp_val is 1 only for code 5 inside that window. Code 6 (don't care) and code 7 never set cmp_valid.
- R8: If no vector is accepted at the last sample, underrun is 1 from the next cycle. While it stays 1, drv_data and drv_en hold and cmp_valid is 0. underrun clears when a vector is accepted or a timeplate write is accepted.
- R9: A timeplate write is accepted when 4 <= spv <= MAX_SPV, edge_at, win_lo and win_hi are each less than spv, and win_lo <= win_hi. An accepted write pulses cfg_ack in the next cycle, aborts any vector in progress, holds drv_data and drv_en, clears underrun, and applies the new timeplate to the next vector.
- R10: A write that breaks any rule in R9 pulses cfg_nack in the next cycle and leaves the timeplate unchanged.
- R11: Vector lengths from 4 samples up to MAX_SPV samples work with the same edge and strobe rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Timeplate write strobe |
| cfg_spv | input | 6 | Samples per vector |
| cfg_edge | input | 6 | Drive edge sample index |
| cfg_win_lo | input | 6 | First strobe sample |
| cfg_win_hi | input | 6 | Last strobe sample |
| cfg_ack | output | 1 | Write accepted (one cycle after cfg_wr) |
| cfg_nack | output | 1 | Write rejected (one cycle after cfg_wr) |
| vec_valid | input | 1 | Vector offered |
| vec_ready | output | 1 | Vector can be taken this cycle |
| vec_codes | input | 3*NUM_CH | State codes, channel n at bits 3n+2:3n |
| drv_data | output | NUM_CH | Drive level per channel |
| drv_en | output | NUM_CH | Drive enable per channel (0 = released) |
| exp_val | output | NUM_CH | Expected level per channel |
| cmp_valid | output | NUM_CH | Compare strobe per channel |
| underrun | output | 1 | Vector stream starved |

## Verification
Two functions can fall in the same cycle. A timeplate write can arrive in the very cycle in which the sequencer would take a new vector. The bench provokes this by raising cfg_wr and vec_valid together while the block is idle. It then checks that vec_ready is low, that the write is acknowledged, and that the same vector is taken one cycle later and runs its full length under the new timeplate. A shift of one sample anywhere in that run shows up in the per-sample ready, drive and strobe checks. A second case writes the timeplate in the middle of a vector, after the drive edge, and checks that the pins keep their driven values.

// File: rtl/tpx_pkg.sv
package tpx_pkg;

    localparam int TP_W   = 6;
    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        PS_D0   = 3'd0,
        PS_D1   = 3'd1,
        PS_DZ   = 3'd2,
        PS_DP   = 3'd3,
        PS_EL   = 3'd4,
        PS_EH   = 3'd5,
        PS_EX   = 3'd6,
        PS_RSV  = 3'd7
    } pin_code_e;

    typedef struct packed {
        logic [TP_W-1:0] spv;
        logic [TP_W-1:0] edge_at;
        logic [TP_W-1:0] win_lo;
        logic [TP_W-1:0] win_hi;
    } timeplate_t;

    typedef struct packed {
        logic data;
        logic en;
    } drive_t;

    function automatic logic code_compares(input logic [CODE_W-1:0] c);
        return (c == PS_EL) || (c == PS_EH);
    endfunction

    function automatic drive_t apply_code(input logic [CODE_W-1:0] c,
                                          input drive_t held);
        drive_t r;
        r = held;
        case (pin_code_e'(c))
            PS_D0:   begin r.data = 1'b0; r.en = 1'b1; end
            PS_D1:   begin r.data = 1'b1; r.en = 1'b1; end
            PS_DP:   r = held;
            default: r.en = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tpx_regs.sv
module tpx_regs
    import tpx_pkg::*;
#(
    parameter int MIN_SPV  = 4,
    parameter int MAX_SPV  = 32,
    parameter int DEF_SPV  = 20,
    parameter int DEF_EDGE = 1,
    parameter int DEF_LO   = 11,
    parameter int DEF_HI   = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  timeplate_t wr_tp,
    output timeplate_t tp,
    output logic       load,
    output logic       ack,
    output logic       nack
);
    localparam logic [TP_W-1:0] MIN_C = TP_W'(MIN_SPV);
    localparam logic [TP_W-1:0] MAX_C = TP_W'(MAX_SPV);

    logic fits;

    always_comb begin
        fits = (wr_tp.spv >= MIN_C) && (wr_tp.spv <= MAX_C)
            && (wr_tp.edge_at < wr_tp.spv)
            && (wr_tp.win_lo  < wr_tp.spv)
            && (wr_tp.win_hi  < wr_tp.spv)
            && (wr_tp.win_lo <= wr_tp.win_hi);
        load = wr && fits;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tp.spv     <= TP_W'(DEF_SPV);
            tp.edge_at <= TP_W'(DEF_EDGE);
            tp.win_lo  <= TP_W'(DEF_LO);
            tp.win_hi  <= TP_W'(DEF_HI);
            ack        <= 1'b0;
            nack       <= 1'b0;
        end else begin
            ack  <= load;
            nack <= wr && !fits;
            if (load) tp <= wr_tp;
        end
    end
endmodule

// File: rtl/tpx_seq.sv
module tpx_seq
    import tpx_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int VEC_W = NUM_CH * CODE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  timeplate_t       tp,
    input  logic             cfg_wr,
    input  logic             load,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] in_codes,
    output logic             in_ready,
    output logic             active,
    output logic [TP_W-1:0]  cnt,
    output logic             underrun,
    output logic [VEC_W-1:0] cur_codes,
    output logic             edge_hit,
    output logic             in_win
);
    logic last;
    logic accept;

    always_comb begin
        last     = active && (cnt == tp.spv - TP_W'(1));
        in_ready = (!active || last) && !cfg_wr;
        accept   = in_valid && in_ready;
        edge_hit = active && (cnt == tp.edge_at);
        in_win   = active && (cnt >= tp.win_lo) && (cnt <= tp.win_hi);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            cnt       <= '0;
            underrun  <= 1'b0;
            cur_codes <= '0;
        end else if (load) begin
            active   <= 1'b0;
            cnt      <= '0;
            underrun <= 1'b0;
        end else if (accept) begin
            active    <= 1'b1;
            cnt       <= '0;
            underrun  <= 1'b0;
            cur_codes <= in_codes;
        end else if (last) begin
            active   <= 1'b0;
            cnt      <= '0;
            underrun <= 1'b1;
        end else if (active) begin
            cnt <= cnt + TP_W'(1);
        end
    end
endmodule

// File: rtl/tpx_lane.sv
module tpx_lane
    import tpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code,
    input  logic              edge_hit,
    input  logic              in_win,
    output logic              drv_data,
    output logic              drv_en,
    output logic              exp_val,
    output logic              cmp_valid
);
    drive_t held;
    drive_t nxt;
    drive_t shown;

    always_comb begin
        nxt       = apply_code(code, held);
        shown     = edge_hit ? nxt : held;
        drv_data  = shown.data;
        drv_en    = shown.en;
        cmp_valid = in_win && code_compares(code);
        exp_val   = cmp_valid && (code == PS_EH);
    end

    always_ff @(posedge clk) begin
        if (rst) held <= '0;
        else if (edge_hit) held <= nxt;
    end
endmodule

// File: rtl/tpx_expander.sv
module tpx_expander
    import tpx_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int MIN_SPV  = 4,
    parameter int MAX_SPV  = 32,
    parameter int DEF_SPV  = 20,
    parameter int DEF_EDGE = 1,
    parameter int DEF_LO   = 11,
    parameter int DEF_HI   = 12,
    localparam int VEC_W   = NUM_CH * CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [TP_W-1:0]   cfg_spv,
    input  logic [TP_W-1:0]   cfg_edge,
    input  logic [TP_W-1:0]   cfg_win_lo,
    input  logic [TP_W-1:0]   cfg_win_hi,
    output logic              cfg_ack,
    output logic              cfg_nack,
    input  logic              vec_valid,
    output logic              vec_ready,
    input  logic [VEC_W-1:0]  vec_codes,
    output logic [NUM_CH-1:0] drv_data,
    output logic [NUM_CH-1:0] drv_en,
    output logic [NUM_CH-1:0] exp_val,
    output logic [NUM_CH-1:0] cmp_valid,
    output logic              underrun
);
    timeplate_t       wr_tp;
    timeplate_t       tp;
    logic             tp_load;
    logic             seq_active;
    logic [TP_W-1:0]  seq_cnt;
    logic [VEC_W-1:0] cur_codes;
    logic             edge_hit;
    logic             in_win;

    always_comb begin
        wr_tp.spv     = cfg_spv;
        wr_tp.edge_at = cfg_edge;
        wr_tp.win_lo  = cfg_win_lo;
        wr_tp.win_hi  = cfg_win_hi;
    end

    tpx_regs #(
        .MIN_SPV(MIN_SPV), .MAX_SPV(MAX_SPV), .DEF_SPV(DEF_SPV),
        .DEF_EDGE(DEF_EDGE), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)
    ) u_regs (
        .clk(clk), .rst(rst), .wr(cfg_wr), .wr_tp(wr_tp), .tp(tp),
        .load(tp_load), .ack(cfg_ack), .nack(cfg_nack)
    );

    tpx_seq #(.NUM_CH(NUM_CH)) u_seq (
        .clk(clk), .rst(rst), .tp(tp), .cfg_wr(cfg_wr), .load(tp_load),
        .in_valid(vec_valid), .in_codes(vec_codes), .in_ready(vec_ready),
        .active(seq_active), .cnt(seq_cnt), .underrun(underrun),
        .cur_codes(cur_codes), .edge_hit(edge_hit), .in_win(in_win)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        tpx_lane u_lane (
            .clk(clk), .rst(rst),
            .code(cur_codes[g*CODE_W +: CODE_W]),
            .edge_hit(edge_hit), .in_win(in_win),
            .drv_data(drv_data[g]), .drv_en(drv_en[g]),
            .exp_val(exp_val[g]), .cmp_valid(cmp_valid[g])
        );
    end
endmodule

// File: rtl/tpx_checker.sv
module tpx_checker
    import tpx_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_wr,
    input logic              cfg_ack,
    input logic              cfg_nack,
    input logic              vec_valid,
    input logic              vec_ready,
    input logic [NUM_CH-1:0] drv_data,
    input logic [NUM_CH-1:0] drv_en,
    input logic [NUM_CH-1:0] cmp_valid,
    input logic              underrun,
    input timeplate_t        tp,
    input logic [TP_W-1:0]   cnt,
    input logic              active
);
    assert_ready_blocked_R2: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |-> !vec_ready);

    assert_accept_restart_R3: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && vec_ready) |=> (active && cnt == '0));

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt < tp.spv));

    assert_strobe_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !active |-> (cmp_valid == '0));

    assert_starve_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (underrun && $past(underrun)) |->
            ($stable(drv_data) && $stable(drv_en) && cmp_valid == '0));

    assert_ack_after_wr_R9: assert property (@(posedge clk) disable iff (rst)
        (cfg_ack || cfg_nack) |-> $past(cfg_wr));

    assert_reject_keeps_R10: assert property (@(posedge clk) disable iff (rst)
        cfg_nack |-> (tp == $past(tp)));
endmodule

bind tpx_expander tpx_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_ack(cfg_ack),
    .cfg_nack(cfg_nack), .vec_valid(vec_valid), .vec_ready(vec_ready),
    .drv_data(drv_data), .drv_en(drv_en), .cmp_valid(cmp_valid),
    .underrun(underrun), .tp(tp), .cnt(seq_cnt), .active(seq_active)
);

// File: tb/tpx_expander_test.sv
module tpx_expander_test;
    localparam int NCH = 8;
    localparam int VW  = 3 * NCH;
    localparam logic [2:0] D0 = 3'd0, D1 = 3'd1, DZ = 3'd2, DP = 3'd3,
                           EL = 3'd4, EH = 3'd5, EX = 3'd6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_wr = 1'b0;
    logic [5:0] cfg_spv = '0, cfg_edge = '0, cfg_win_lo = '0, cfg_win_hi = '0;
    logic cfg_ack, cfg_nack;
    logic vec_valid = 1'b0;
    logic vec_ready;
    logic [VW-1:0] vec_codes = '0;
    logic [NCH-1:0] drv_data, drv_en, exp_val, cmp_valid;
    logic underrun;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    int t_spv = 20, t_edge = 1, t_lo = 11, t_hi = 12;
    logic [NCH-1:0] m_data = '0, m_en = '0;
    logic [VW-1:0] vq [8];

    always #5 clk = ~clk;

    tpx_expander uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_spv(cfg_spv),
        .cfg_edge(cfg_edge), .cfg_win_lo(cfg_win_lo), .cfg_win_hi(cfg_win_hi),
        .cfg_ack(cfg_ack), .cfg_nack(cfg_nack), .vec_valid(vec_valid),
        .vec_ready(vec_ready), .vec_codes(vec_codes), .drv_data(drv_data),
        .drv_en(drv_en), .exp_val(exp_val), .cmp_valid(cmp_valid),
        .underrun(underrun)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    // Bench model of the drive edge, taken from R4, R5 and R6
    task automatic model_edge(input logic [VW-1:0] v);
        for (int c = 0; c < NCH; c++) begin
            logic [2:0] k;
            k = v[3*c +: 3];
            if (k == D0) begin m_data[c] = 1'b0; m_en[c] = 1'b1; end
            else if (k == D1) begin m_data[c] = 1'b1; m_en[c] = 1'b1; end
            else if (k != DP) m_en[c] = 1'b0;
        end
    endtask

    // Called at a negedge, block idle: streams vq[0..n-1] back to back
    task automatic run_stream(input int n, input string tag);
        vec_valid = 1'b1;
        vec_codes = vq[0];
        #1 chk("R2", "ready when idle", 32'(vec_ready), 32'd1);
        @(negedge clk);
        for (int v = 0; v < n; v++) begin
            for (int s = 0; s < t_spv; s++) begin
                logic [NCH-1:0] e_cmp, e_exp;
                if (s == t_edge) model_edge(vq[v]);
                for (int c = 0; c < NCH; c++) begin
                    logic [2:0] k;
                    k = vq[v][3*c +: 3];
                    e_cmp[c] = (s >= t_lo) && (s <= t_hi) && (k == EL || k == EH);
                    e_exp[c] = e_cmp[c] && (k == EH);
                end
                if (s == t_spv - 1) begin
                    if (v + 1 < n) vec_codes = vq[v+1];
                    else vec_valid = 1'b0;
                end
                #1;
                chk(tag, "drv_data", 32'(drv_data), 32'(m_data));
                chk("R5", "drv_en", 32'(drv_en), 32'(m_en));
                chk("R7", "cmp_valid", 32'(cmp_valid), 32'(e_cmp));
                chk("R7", "exp_val", 32'(exp_val), 32'(e_exp));
                chk("R3", "ready timing", 32'(vec_ready), 32'(s == t_spv - 1));
                @(negedge clk);
            end
        end
        #1;
        chk("R8", "underrun set", 32'(underrun), 32'd1);
        chk("R8", "held data", 32'(drv_data), 32'(m_data));
        chk("R8", "held en", 32'(drv_en), 32'(m_en));
        chk("R8", "no strobe", 32'(cmp_valid), 32'd0);
        @(negedge clk);
        chk("R8", "still starved", 32'(underrun), 32'd1);
        chk("R8", "still held", 32'(drv_data), 32'(m_data));
    endtask

    // Called at a negedge
    task automatic cfg_write(input int spv, input int ed, input int lo,
                             input int hi, input bit good, input string tag);
        cfg_wr = 1'b1;
        cfg_spv = 6'(spv); cfg_edge = 6'(ed); cfg_win_lo = 6'(lo); cfg_win_hi = 6'(hi);
        #1 chk("R2", "ready during write", 32'(vec_ready), 32'd0);
        @(negedge clk);
        cfg_wr = 1'b0;
        #1;
        chk(tag, "cfg_ack", 32'(cfg_ack), 32'(good));
        chk(tag, "cfg_nack", 32'(cfg_nack), 32'(!good));
        if (good) begin
            t_spv = spv; t_edge = ed; t_lo = lo; t_hi = hi;
            chk("R9", "underrun cleared", 32'(underrun), 32'd0);
            chk("R9", "held data", 32'(drv_data), 32'(m_data));
            chk("R9", "held en", 32'(drv_en), 32'(m_en));
            chk("R9", "no strobe", 32'(cmp_valid), 32'd0);
            chk("R9", "ready after", 32'(vec_ready), 32'd1);
        end
    endtask

    task automatic test_reset();
        #1;
        chk("R1", "drv_data", 32'(drv_data), 32'd0);
        chk("R1", "drv_en", 32'(drv_en), 32'd0);
        chk("R1", "cmp_valid", 32'(cmp_valid), 32'd0);
        chk("R1", "exp_val", 32'(exp_val), 32'd0);
        chk("R1", "ready", 32'(vec_ready), 32'd1);
        chk("R1", "underrun", 32'(underrun), 32'd0);
        chk("R1", "ack/nack", 32'({cfg_ack, cfg_nack}), 32'd0);
    endtask

    task automatic test_mixed();
        vq[0] = {D0, D1, EH, EL, DZ, EX, D1, D0};
        vq[1] = {EL, EH, D1, D0, D1, EH, EX, DZ};
        vq[2] = {D1, D0, EX, EH, EL, D1, D0, EH};
        run_stream(3, "R4");
    endtask

    task automatic test_repeat();
        vq[0] = {D1, D0, D1, D0, D1, D0, D1, D0};
        vq[1] = {DP, DP, DP, DP, DP, DP, DP, DP};
        vq[2] = {DZ, DZ, DP, DP, DZ, DZ, DP, DP};
        vq[3] = {DP, DP, DP, DP, DP, DP, DP, DP};
        run_stream(4, "R6");
    endtask

    task automatic test_rejects();
        cfg_write(3, 1, 1, 2, 1'b0, "R10");
        cfg_write(33, 1, 11, 12, 1'b0, "R10");
        cfg_write(20, 20, 11, 12, 1'b0, "R10");
        cfg_write(20, 1, 12, 11, 1'b0, "R10");
        cfg_write(20, 1, 11, 20, 1'b0, "R10");
        vq[0] = {EH, EL, D0, D1, EX, EH, EL, D1};
        run_stream(1, "R10");
    endtask

    task automatic test_midway();
        vec_valid = 1'b1;
        vec_codes = {NCH{D1}};
        @(negedge clk);
        vec_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        model_edge({NCH{D1}});
        #1 chk("R4", "edge applied", 32'(drv_data), 32'(m_data));
        cfg_write(4, 0, 1, 2, 1'b1, "R9");
    endtask

    task automatic test_short();
        vq[0] = {D0, D0, EH, EL, D1, D1, EX, DZ};
        vq[1] = {DP, D1, EL, EH, D0, DZ, D1, EX};
        vq[2] = {EH, EH, D0, D1, EL, EL, DZ, D0};
        run_stream(3, "R11");
    endtask

    task automatic test_collide();
        vq[0] = {EL, D1, D0, EH, EX, D1, EL, D0};
        cfg_wr = 1'b1;
        cfg_spv = 6'd20; cfg_edge = 6'd1; cfg_win_lo = 6'd11; cfg_win_hi = 6'd12;
        vec_valid = 1'b1;
        vec_codes = vq[0];
        #1 chk("R2", "ready blocked by write", 32'(vec_ready), 32'd0);
        @(negedge clk);
        cfg_wr = 1'b0;
        #1;
        chk("R9", "ack on collision", 32'(cfg_ack), 32'd1);
        chk("R2", "ready after write", 32'(vec_ready), 32'd1);
        t_spv = 20; t_edge = 1; t_lo = 11; t_hi = 12;
        run_stream(1, "R2");
    endtask

    task automatic test_long();
        cfg_write(32, 31, 30, 31, 1'b1, "R9");
        vq[0] = {D1, EH, D0, EL, D1, DZ, EH, D0};
        vq[1] = {EL, D0, EH, D1, DP, D1, EX, EH};
        run_stream(2, "R11");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_mixed();
        test_repeat();
        test_rejects();
        test_midway();
        test_short();
        test_collide();
        test_long();
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        #(10 * 150000);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule